// File: doc/BRIEF.md
# Programmable Ternary Lookup Element

This block maps three balanced-ternary input trits to one output trit through a table that software or a neighbouring block loads at run time. Every trit travels on two wires and can hold minus, zero, plus or a fourth "null" value meaning that no data is present. Null is contagious: a null on any input, or a table slot left undefined, yields a null result. Downstream merge logic can then pick the one live path out of several.

The table holds one slot for every combination of the three inputs, 27 in all. A parallel write port replaces the whole table on one clock edge. Lookups are combinational from the stored table by default, and a parameter can add an output register. A function of one or two inputs is stored by repeating its 3 or 9 results across the table. The unused leading inputs then have no effect.

Top module: `ternary_lut`

## Requirements
- R1: After reset every table slot is null (2'b00), so the output is null for every input pattern until the first load.
- R2: When `cfg_load_i` is high at a rising clock edge, `cfg_table_i` replaces the whole table from that edge on. While the strobe is low, changes on `cfg_table_i` have no effect on the output.
- R3: Trit code: 2'b00 null, 2'b01 zero, 2'b10 minus, 2'b11 plus. `trit_in_i[5:4]` is the most significant trit t2 and `trit_in_i[1:0]` is t0. The slot index is (t2+1)*9 + (t1+1)*3 + (t0+1), and slot k sits at `cfg_table_i[2k+1:2k]`. So (-,-,-) selects slot 0, (0,0,0) selects slot 13 and (+,+,+) selects slot 26.
- R4: If any input trit is null, the output is null whatever the table holds.
- R5: If all inputs are non-null and the selected slot holds null (undefined), the output is null.
- R6: If all inputs are non-null, the output equals the code stored in the selected slot.
- R7: A table made of 3 values repeated 9 times makes the output depend only on t0. A table made of 9 values repeated 3 times makes it depend only on t1 and t0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_load_i | input | 1 | Table write strobe |
| cfg_table_i | input | 54 | New table contents, two bits per slot |
| trit_in_i | input | 6 | Three input trits, t2 in the top pair |
| trit_out_o | output | 2 | Looked-up output trit |

## Verification
The bench places a single live slot at the two ends and at the middle of the table. A design that reversed trit significance or the slot order would report the wrong slot there. It puts null in each input position in turn, against a table with no null slots. A design that only screened some positions would leak a table value. It changes the load data with the strobe low, and a design that wrote through would change its output. It also loads repeated one- and two-input tables and drives random values on the unused inputs. A miscomputed stride would make the output follow those inputs.

// File: rtl/tlut_pkg.sv
package tlut_pkg;
  typedef logic [1:0] trit_t;
  localparam trit_t TRIT_NULL  = 2'b00;
  localparam trit_t TRIT_ZERO  = 2'b01;
  localparam trit_t TRIT_MINUS = 2'b10;
  localparam trit_t TRIT_PLUS  = 2'b11;

  // digit weight of a non-null trit: minus 0, zero 1, plus 2
  function automatic int unsigned trit_digit(trit_t t);
    case (t)
      TRIT_MINUS: return 0;
      TRIT_ZERO:  return 1;
      default:    return 2;
    endcase
  endfunction
endpackage

// File: rtl/tlut_store.sv
module tlut_store #(
  parameter int unsigned TBL_W = 54
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [TBL_W-1:0] data_i,
  output logic [TBL_W-1:0] table_o
);
  logic [TBL_W-1:0] tbl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     tbl_q <= '0;
    else if (load_i) tbl_q <= data_i;
  end

  assign table_o = tbl_q;
endmodule

// File: rtl/tlut_index.sv
module tlut_index
  import tlut_pkg::*;
#(
  parameter int unsigned N_IN  = 3,
  parameter int unsigned IDX_W = 5
) (
  input  logic [2*N_IN-1:0] trits_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic              any_null_o
);
  trit_t slot [N_IN];
  logic [N_IN-1:0] is_null;

  for (genvar g = 0; g < N_IN; g++) begin : g_split
    assign slot[g]    = trits_i[2*g +: 2];
    assign is_null[g] = (trits_i[2*g +: 2] == TRIT_NULL);
  end

  always_comb begin
    int unsigned acc;
    acc = 0;
    // most significant trit first
    for (int i = N_IN - 1; i >= 0; i--) begin
      acc = acc * 3 + trit_digit(slot[i]);
    end
    idx_o = IDX_W'(acc);
  end

  assign any_null_o = |is_null;
endmodule

// File: rtl/tlut_select.sv
module tlut_select
  import tlut_pkg::*;
#(
  parameter int unsigned ENTRIES = 27,
  parameter int unsigned IDX_W   = 5
) (
  input  logic [2*ENTRIES-1:0] table_i,
  input  logic [IDX_W-1:0]     idx_i,
  input  logic                 any_null_i,
  output trit_t                trit_o
);
  trit_t ent [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    assign ent[g] = table_i[2*g +: 2];
  end

  trit_t picked;
  always_comb begin
    picked = TRIT_NULL;
    for (int k = 0; k < ENTRIES; k++) begin
      if (idx_i == IDX_W'(k)) picked = ent[k];
    end
  end

  assign trit_o = any_null_i ? TRIT_NULL : picked;
endmodule

// File: rtl/ternary_lut.sv
module ternary_lut
  import tlut_pkg::*;
#(
  parameter int unsigned N_IN    = 3,
  parameter bit          REG_OUT = 1'b0,
  localparam int unsigned ENTRIES = 3 ** N_IN,
  localparam int unsigned TBL_W   = 2 * ENTRIES,
  localparam int unsigned IDX_W   = $clog2(ENTRIES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_load_i,
  input  logic [TBL_W-1:0]  cfg_table_i,
  input  logic [2*N_IN-1:0] trit_in_i,
  output logic [1:0]        trit_out_o
);
  logic [TBL_W-1:0] tbl;
  logic [IDX_W-1:0] idx;
  logic             any_null;
  trit_t            lut_out;

  tlut_store #(.TBL_W(TBL_W)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (cfg_load_i),
    .data_i  (cfg_table_i),
    .table_o (tbl)
  );

  tlut_index #(.N_IN(N_IN), .IDX_W(IDX_W)) u_index (
    .trits_i    (trit_in_i),
    .idx_o      (idx),
    .any_null_o (any_null)
  );

  tlut_select #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_select (
    .table_i    (tbl),
    .idx_i      (idx),
    .any_null_i (any_null),
    .trit_o     (lut_out)
  );

  if (REG_OUT) begin : g_reg
    trit_t out_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) out_q <= TRIT_NULL;
      else         out_q <= lut_out;
    end
    assign trit_out_o = out_q;
  end else begin : g_comb
    assign trit_out_o = lut_out;
  end
endmodule

// File: rtl/tlut_checker.sv
module tlut_checker #(
  parameter int unsigned N_IN    = 3,
  parameter bit          REG_OUT = 1'b0,
  localparam int unsigned ENTRIES = 3 ** N_IN,
  localparam int unsigned TBL_W   = 2 * ENTRIES
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_load_i,
  input logic [TBL_W-1:0]  cfg_table_i,
  input logic [2*N_IN-1:0] trit_in_i,
  input logic [1:0]        trit_out_o
);
  logic [TBL_W-1:0] shadow_q;
  logic             loaded_q;
  logic [1:0]       exp_c, exp_q, ref_out;
  logic             in_null, slot_null;

  function automatic int unsigned slot_of(logic [2*N_IN-1:0] t);
    int unsigned a;
    a = 0;
    for (int i = N_IN - 1; i >= 0; i--) begin
      a = a * 3 + ((t[2*i +: 2] == 2'b10) ? 0 : (t[2*i +: 2] == 2'b01) ? 1 : 2);
    end
    return a;
  endfunction

  always_comb begin
    in_null = 1'b0;
    for (int i = 0; i < N_IN; i++) if (trit_in_i[2*i +: 2] == 2'b00) in_null = 1'b1;
    slot_null = (shadow_q[2*slot_of(trit_in_i) +: 2] == 2'b00);
    exp_c = in_null ? 2'b00 : shadow_q[2*slot_of(trit_in_i) +: 2];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= '0;
      loaded_q <= 1'b0;
      exp_q    <= 2'b00;
    end else begin
      if (cfg_load_i) begin
        shadow_q <= cfg_table_i;
        loaded_q <= 1'b1;
      end
      exp_q <= exp_c;
    end
  end

  assign ref_out = REG_OUT ? exp_q : exp_c;

  AST_RESET_NULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !loaded_q |-> trit_out_o == 2'b00); // R1
  AST_LOOKUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trit_out_o == ref_out); // R6

  if (!REG_OUT) begin : g_comb_chk
    AST_NULL_IN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      in_null |-> trit_out_o == 2'b00); // R4
    AST_UNDEF_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      slot_null |-> trit_out_o == 2'b00); // R5
    AST_HOLD_NO_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!$past(cfg_load_i) && $stable(trit_in_i)) |-> $stable(trit_out_o)); // R2
  end else begin : g_reg_chk
    AST_NULL_IN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      in_null |=> trit_out_o == 2'b00); // R4
    AST_UNDEF_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (slot_null && !cfg_load_i) |=> trit_out_o == 2'b00); // R5
  end
endmodule

bind ternary_lut tlut_checker #(.N_IN(N_IN), .REG_OUT(REG_OUT)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_load_i  (cfg_load_i),
  .cfg_table_i (cfg_table_i),
  .trit_in_i   (trit_in_i),
  .trit_out_o  (trit_out_o)
);

// File: tb/ternary_lut_tb_top.sv
module ternary_lut_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] TN = 2'b00, TZ = 2'b01, TM = 2'b10, TP = 2'b11;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        load;
  logic [53:0] cfg;
  logic [5:0]  tin;
  logic [1:0]  tout;
  logic [53:0] model;
  int          n_cmp = 0, n_err = 0;
  bit          done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ternary_lut dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_load_i(load),
    .cfg_table_i(cfg), .trit_in_i(tin), .trit_out_o(tout)
  );

  function automatic int dig(logic [1:0] t);
    return (t == TM) ? 0 : (t == TZ) ? 1 : 2;
  endfunction

  function automatic int idx_of(logic [5:0] t);
    return dig(t[5:4]) * 9 + dig(t[3:2]) * 3 + dig(t[1:0]);
  endfunction

  function automatic logic [1:0] expect_out(logic [5:0] t);
    if (t[5:4] == TN || t[3:2] == TN || t[1:0] == TN) return TN;
    return model[2*idx_of(t) +: 2];
  endfunction

  function automatic logic [1:0] nn_trit();
    case ($urandom % 3)
      0: return TM;
      1: return TZ;
      default: return TP;
    endcase
  endfunction

  function automatic logic [5:0] combo(int k);
    logic [1:0] d [3];
    int r;
    r = k;
    for (int i = 0; i < 3; i++) begin
      d[i] = (r % 3 == 0) ? TM : (r % 3 == 1) ? TZ : TP;
      r = r / 3;
    end
    return {d[2], d[1], d[0]};
  endfunction

  task automatic check(string req, logic [1:0] act, logic [1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s in=%b actual=%b expected=%b", req, tin, act, exp);
    end
  endtask

  task automatic load_table(logic [53:0] t);
    @(negedge clk);
    cfg  = t;
    load = 1'b1;
    @(negedge clk);
    load  = 1'b0;
    model = t;
  endtask

  task automatic probe(string req, logic [5:0] t, logic [1:0] exp);
    @(negedge clk);
    tin = t;
    #1;
    check(req, tout, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
      $finish;
    end
  end

  initial begin
    logic [53:0] t;
    logic [1:0]  v3 [3];
    logic [1:0]  v9 [9];
    void'($urandom(32'h5eed_0017));
    rst_n = 1'b0; load = 1'b0; cfg = '0; tin = '0; model = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset table is all null
    for (int k = 0; k < 27; k += 4) probe("R1", combo(k), TN);

    // R3: single live slot at ends and middle
    for (int s = 0; s < 4; s++) begin
      int tgt;
      tgt = (s == 0) ? 0 : (s == 1) ? 13 : (s == 2) ? 26 : 1;
      t = '0;
      for (int k = 0; k < 27; k++) t[2*k +: 2] = (k == tgt) ? TP : TZ;
      load_table(t);
      for (int k = 0; k < 27; k++) probe("R3", combo(k), (k == tgt) ? TP : TZ);
    end
    probe("R3", {TM, TM, TZ}, TP);  // slot 1
    probe("R3", {TZ, TM, TM}, TZ);  // slot 9

    // R4: null on each position against a table with no null slots
    t = '0;
    for (int k = 0; k < 27; k++) t[2*k +: 2] = nn_trit();
    load_table(t);
    for (int k = 0; k < 27; k++) begin
      logic [5:0] c;
      c = combo(k);
      probe("R4", {TN, c[3:0]}, TN);
      probe("R4", {c[5:4], TN, c[1:0]}, TN);
      probe("R4", {c[5:2], TN}, TN);
    end

    // R2: data changes without strobe are ignored
    @(negedge clk);
    cfg = ~t;
    repeat (2) @(negedge clk);
    for (int k = 0; k < 27; k++) probe("R2", combo(k), t[2*k +: 2]);

    // R5/R6: random table with null slots, full sweep
    for (int rep = 0; rep < 3; rep++) begin
      t = '0;
      for (int k = 0; k < 27; k++) t[2*k +: 2] = 2'($urandom % 4);
      load_table(t);
      for (int k = 0; k < 27; k++)
        probe((t[2*k +: 2] == TN) ? "R5" : "R6", combo(k), t[2*k +: 2]);
    end

    // R7: one-input function replicated 9 times
    for (int i = 0; i < 3; i++) v3[i] = nn_trit();
    for (int k = 0; k < 27; k++) t[2*k +: 2] = v3[k % 3];
    load_table(t);
    for (int n = 0; n < 30; n++) begin
      logic [1:0] a;
      a = nn_trit();
      probe("R7", {nn_trit(), nn_trit(), a}, v3[dig(a)]);
    end
    // R7: two-input function replicated 3 times
    for (int i = 0; i < 9; i++) v9[i] = 2'($urandom % 4);
    for (int k = 0; k < 27; k++) t[2*k +: 2] = v9[k % 9];
    load_table(t);
    for (int n = 0; n < 40; n++) begin
      logic [1:0] a, b;
      a = nn_trit(); b = nn_trit();
      probe("R7", {nn_trit(), b, a}, v9[dig(b) * 3 + dig(a)]);
    end

    // R6: random mix with occasional reloads
    for (int n = 0; n < 400; n++) begin
      logic [5:0] c;
      if (n % 80 == 0) begin
        for (int k = 0; k < 27; k++) t[2*k +: 2] = 2'($urandom % 4);
        load_table(t);
      end
      c = 6'($urandom);
      probe("R6", c, expect_out(c));
    end

    // R1: reset clears a loaded table
    @(negedge clk);
    rst_n = 1'b0;
    model = '0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < 27; k += 2) probe("R1", combo(k), TN);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end
endmodule